// File: doc/BRIEF.md
# Frame-Header Slot Map Filter

This block sits on the receive byte path of a radio MAC. Most packets go past it untouched. When the sequencer marks the next packet as a frame header, the block scans that packet's slot map and keeps only the entries that concern this station. It writes those entries into a small FIFO, and host software reads them from there. This takes the byte-level work of scanning the map off the software.

The header is a fixed-size block of 27 bytes. Cells of 54 bytes follow it, and the last CRC bytes of each cell are not slot map data. The slot map starts a configurable number of data bytes into the payload and runs across cell boundaries. It ends either at an end-marker entry or after a fixed number of entries. Software loads its own station identifier once, before any parsing is wanted.

Top module: `fh_slotmap_filter`

## Requirements
- R1: After reset, `pf_empty` is 1, and `pf_full`, `pf_ovf` and `pf_data_vld` are 0.
- R2: A packet is parsed only if `fh_mark` was high in a cycle after the previous packet's last byte and no later than its own first byte. A mark applies to that one packet only, and every other packet adds nothing to the FIFO.
- R3: Until `sta_load` has captured a station identifier, no entry is written to the FIFO, not even a broadcast entry.
- R4: The first 27 bytes of a packet are header and are skipped. After that, the last `CRC_BYTES` (default 4) bytes of every 54-byte cell are skipped. The map begins `MAP_OFS` (default 4) data bytes into the payload, and an entry may straddle a cell boundary.
- R5: Each entry is 4 bytes, sent most significant byte first, and forms a 32-bit word. Bits 31:29 hold the type, bit 28 is spare, bits 27:16 hold the station ID, bits 15:8 hold the VC/queue ID and bits 7:0 hold the slot index. The word is written to the FIFO unchanged.
- R6: Type 1 (uplink reservation) and type 3 (downlink unicast) entries are forwarded only when their station ID equals the loaded identifier.
- R7: Type 2 (uplink contention) entries are forwarded when their station ID is 0 or equals the loaded identifier. Type 4 (downlink broadcast/multicast) entries are always forwarded. Type 0 (void), type 5 and type 6 entries are never forwarded. The spare bit has no effect on the decision.
- R8: The scan stops at a type 7 entry, which is itself not forwarded, or after `MAX_ENTRIES` (default 16) entries. Entries after that point are ignored.
- R9: The FIFO keeps entries in arrival order. A `pf_rd` when the FIFO is not empty gives `pf_data` with `pf_data_vld` high on the next cycle. A `pf_rd` when it is empty gives no `pf_data_vld`.
- R10: An entry that arrives while the FIFO is full is dropped and sets `pf_ovf`. `pf_ovf` stays set until reset.
- R11: An entry that arrives while the FIFO is full, in the same cycle as a valid read, is stored and does not set `pf_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sta_load | input | 1 | Strobe that captures `sta_id_in` as this station's identifier |
| sta_id_in | input | 12 | Station identifier to load |
| fh_mark | input | 1 | Marks the next packet as a frame header |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| rx_last | input | 1 | Last byte of the packet |
| pf_rd | input | 1 | Read strobe for the entry FIFO |
| pf_data | output | 32 | Entry read from the FIFO |
| pf_data_vld | output | 1 | `pf_data` holds a freshly read entry |
| pf_empty | output | 1 | FIFO holds no entries |
| pf_full | output | 1 | FIFO is full |
| pf_ovf | output | 1 | Sticky flag: a matching entry was dropped |

## Verification
The write of a matching entry and a host read can land on the same clock edge while the FIFO is full. In that case the read must free a place for the write, and the entry must not be counted as lost. The bench first fills the FIFO with a frame header. It then sends a second frame header and drives `pf_rd` for exactly the cycle in which the decision on the entry reaches the FIFO. It judges the result from three things: the word read in that cycle is the oldest entry, `pf_ovf` stays clear, and the new entry comes out last when the FIFO is drained.

// File: rtl/fhsm_pkg.sv
package fhsm_pkg;
  localparam int STA_W = 12;
  localparam int ENT_W = 32;

  typedef enum logic [2:0] {
    ET_VOID    = 3'd0,
    ET_UL_RES  = 3'd1,
    ET_UL_CONT = 3'd2,
    ET_DL_UNI  = 3'd3,
    ET_DL_BMC  = 3'd4,
    ET_RSV5    = 3'd5,
    ET_RSV6    = 3'd6,
    ET_END     = 3'd7
  } ent_type_e;

  typedef struct packed {
    ent_type_e        etype;
    logic             spare;
    logic [STA_W-1:0] sta;
    logic [7:0]       vc;
    logic [7:0]       slot;
  } slot_ent_t;
endpackage

// File: rtl/fhsm_stream_pos.sv
// Tracks the byte position inside a packet and flags the bytes that belong
// to the slot map of a packet marked as a frame header.
module fhsm_stream_pos #(
  parameter int HDR_BYTES  = 27,
  parameter int CELL_BYTES = 54,
  parameter int CRC_BYTES  = 4,
  parameter int MAP_OFS    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fh_mark,
  input  logic rx_valid,
  input  logic rx_last,
  output logic sop,
  output logic map_vld
);
  localparam int HW         = $clog2(HDR_BYTES + 1);
  localparam int CW         = $clog2(CELL_BYTES + 1);
  localparam int OW         = $clog2(MAP_OFS + 2);
  localparam int DATA_BYTES = CELL_BYTES - CRC_BYTES;

  logic          in_pkt, in_cells, armed, pkt_fh;
  logic [HW-1:0] hdr_cnt;
  logic [CW-1:0] cell_cnt;
  logic [OW-1:0] ofs_cnt;
  logic          is_data, ofs_done;

  assign sop      = rx_valid && !in_pkt;
  assign is_data  = in_cells && (cell_cnt < CW'(DATA_BYTES));
  assign ofs_done = (ofs_cnt == OW'(MAP_OFS));
  assign map_vld  = rx_valid && pkt_fh && is_data && ofs_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt   <= 1'b0;
      in_cells <= 1'b0;
      armed    <= 1'b0;
      pkt_fh   <= 1'b0;
      hdr_cnt  <= '0;
      cell_cnt <= '0;
      ofs_cnt  <= '0;
    end else begin
      if (fh_mark) armed <= 1'b1;
      if (sop) begin
        armed  <= 1'b0;
        pkt_fh <= armed | fh_mark;
        in_pkt <= 1'b1;
      end
      if (rx_valid) begin
        if (!in_cells) begin
          if (hdr_cnt == HW'(HDR_BYTES - 1)) begin
            in_cells <= 1'b1;
            hdr_cnt  <= '0;
          end else begin
            hdr_cnt <= hdr_cnt + 1'b1;
          end
        end else begin
          cell_cnt <= (cell_cnt == CW'(CELL_BYTES - 1)) ? '0 : cell_cnt + 1'b1;
          if (is_data && !ofs_done) ofs_cnt <= ofs_cnt + 1'b1;
        end
        if (rx_last) begin
          in_pkt   <= 1'b0;
          pkt_fh   <= 1'b0;
          in_cells <= 1'b0;
          hdr_cnt  <= '0;
          cell_cnt <= '0;
          ofs_cnt  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fhsm_ent_match.sv
// Assembles 4-byte map entries and decides which ones concern this station.
module fhsm_ent_match
  import fhsm_pkg::*;
#(
  parameter int MAX_ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sop,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             sta_ok,
  input  logic [STA_W-1:0] my_sta,
  output logic             push,
  output slot_ent_t        push_ent
);
  localparam int EW = $clog2(MAX_ENTRIES + 1);

  logic [1:0]    bcnt;
  logic [23:0]   hold;
  logic [EW-1:0] ecnt;
  logic          stopped;
  slot_ent_t     ent;
  logic          own, fwd, last_b;

  assign ent    = slot_ent_t'({hold, byte_in});
  assign own    = (ent.sta == my_sta);
  assign last_b = byte_vld && !stopped && (bcnt == 2'd3);

  always_comb begin
    unique case (ent.etype)
      ET_UL_RES, ET_DL_UNI: fwd = own;
      ET_UL_CONT:           fwd = own || (ent.sta == '0);
      ET_DL_BMC:            fwd = 1'b1;
      default:              fwd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || sop) begin
      bcnt    <= '0;
      hold    <= '0;
      ecnt    <= '0;
      stopped <= 1'b0;
      push    <= 1'b0;
    end else begin
      push <= last_b && fwd && sta_ok;
      if (byte_vld && !stopped) begin
        bcnt <= bcnt + 1'b1;
        hold <= {hold[15:0], byte_in};
        if (bcnt == 2'd3) begin
          ecnt <= ecnt + 1'b1;
          if (ent.etype == ET_END || ecnt == EW'(MAX_ENTRIES - 1)) stopped <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (last_b) push_ent <= ent;
  end
endmodule

// File: rtl/fhsm_fifo.sv
// Synchronous FIFO with a registered read port; DEPTH must be a power of two.
module fhsm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         rvld,
  output logic         empty,
  output logic         full,
  output logic         wr_drop
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         rd_fire, wr_fire;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign rd_fire = rd && !empty;
  assign wr_fire = wr && (!full || rd_fire);
  assign wr_drop = wr && !wr_fire;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr[AW-1:0]] <= wdata;
    if (rd_fire) rdata <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      rvld <= 1'b0;
    end else begin
      rvld <= rd_fire;
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rd_fire) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/fh_slotmap_filter.sv
module fh_slotmap_filter
  import fhsm_pkg::*;
#(
  parameter int HDR_BYTES   = 27,
  parameter int CELL_BYTES  = 54,
  parameter int CRC_BYTES   = 4,
  parameter int MAP_OFS     = 4,
  parameter int MAX_ENTRIES = 16,
  parameter int DEPTH       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sta_load,
  input  logic [STA_W-1:0] sta_id_in,
  input  logic             fh_mark,
  input  logic [7:0]       rx_byte,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic             pf_rd,
  output logic [ENT_W-1:0] pf_data,
  output logic             pf_data_vld,
  output logic             pf_empty,
  output logic             pf_full,
  output logic             pf_ovf
);
  logic             sop, map_vld, push, wr_drop;
  slot_ent_t        push_ent;
  logic [STA_W-1:0] sta_q;
  logic             sta_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      sta_q   <= '0;
      sta_vld <= 1'b0;
      pf_ovf  <= 1'b0;
    end else begin
      if (sta_load) begin
        sta_q   <= sta_id_in;
        sta_vld <= 1'b1;
      end
      if (wr_drop) pf_ovf <= 1'b1;
    end
  end

  fhsm_stream_pos #(
    .HDR_BYTES(HDR_BYTES), .CELL_BYTES(CELL_BYTES),
    .CRC_BYTES(CRC_BYTES), .MAP_OFS(MAP_OFS)
  ) i_pos (
    .clk(clk), .rst(rst), .fh_mark(fh_mark), .rx_valid(rx_valid),
    .rx_last(rx_last), .sop(sop), .map_vld(map_vld)
  );

  fhsm_ent_match #(.MAX_ENTRIES(MAX_ENTRIES)) i_match (
    .clk(clk), .rst(rst), .sop(sop), .byte_vld(map_vld), .byte_in(rx_byte),
    .sta_ok(sta_vld), .my_sta(sta_q), .push(push), .push_ent(push_ent)
  );

  fhsm_fifo #(.W(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .wr(push), .wdata(push_ent), .rd(pf_rd),
    .rdata(pf_data), .rvld(pf_data_vld), .empty(pf_empty), .full(pf_full),
    .wr_drop(wr_drop)
  );
endmodule

// File: rtl/fhsm_checker.sv
module fhsm_checker (
  input logic clk,
  input logic rst,
  input logic pf_rd,
  input logic pf_data_vld,
  input logic pf_empty,
  input logic pf_full,
  input logic pf_ovf
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pf_empty && !pf_full && !pf_ovf && !pf_data_vld)); // R1
  AST_READ_GIVES_DATA: assert property (@(posedge clk) disable iff (rst) (pf_rd && !pf_empty) |=> pf_data_vld); // R9
  AST_EMPTY_READ_SILENT: assert property (@(posedge clk) disable iff (rst) (pf_rd && pf_empty) |=> !pf_data_vld); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) pf_ovf |=> pf_ovf); // R10
  AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) $rose(pf_ovf) |-> $past(pf_full)); // R10

  always @(posedge clk) begin
    if (!rst) begin
      AST_FULL_NOT_EMPTY: assert (!(pf_full && pf_empty)); // R9
    end
  end
endmodule

bind fh_slotmap_filter fhsm_checker i_chk (
  .clk(clk), .rst(rst), .pf_rd(pf_rd), .pf_data_vld(pf_data_vld),
  .pf_empty(pf_empty), .pf_full(pf_full), .pf_ovf(pf_ovf)
);

// File: tb/test_fh_slotmap_filter.sv
module test_fh_slotmap_filter;
  localparam int HDR = 27, CELL = 54, CRC = 4, OFS = 4, MAXE = 16, DEPTH = 8;
  localparam int DATA = CELL - CRC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sta_load = 1'b0;
  logic [11:0] sta_id_in = '0;
  logic        fh_mark = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_last = 1'b0;
  logic        pf_rd = 1'b0;
  logic [31:0] pf_data;
  logic        pf_data_vld, pf_empty, pf_full, pf_ovf;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0]  pl[$];
  logic [7:0]  strm[$];
  logic [31:0] expq[$];

  // {forward expected, entry word} with own station 0x5A3
  localparam logic [32:0] VEC [12] = '{
    {1'b1, 32'h25A3_0110},  // R6 reservation, own
    {1'b0, 32'h2123_0211},  // R6 reservation, other
    {1'b1, 32'h4000_0312},  // R7 contention, id 0
    {1'b1, 32'h45A3_0413},  // R7 contention, own
    {1'b0, 32'h4777_0514},  // R7 contention, other
    {1'b1, 32'h65A3_0615},  // R6 unicast, own
    {1'b0, 32'h65A2_0716},  // R6 unicast, other
    {1'b1, 32'h8999_0817},  // R7 broadcast
    {1'b0, 32'h05A3_0918},  // R7 void
    {1'b0, 32'hA5A3_0A19},  // R7 type 5
    {1'b0, 32'hC5A3_0B1A},  // R7 type 6
    {1'b1, 32'h75A3_0C1B}   // R7 spare set, R4 straddles cell boundary
  };

  fh_slotmap_filter #(
    .HDR_BYTES(HDR), .CELL_BYTES(CELL), .CRC_BYTES(CRC), .MAP_OFS(OFS),
    .MAX_ENTRIES(MAXE), .DEPTH(DEPTH)
  ) i_fh_slotmap_filter (
    .clk(clk), .rst(rst), .sta_load(sta_load), .sta_id_in(sta_id_in),
    .fh_mark(fh_mark), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
    .pf_rd(pf_rd), .pf_data(pf_data), .pf_data_vld(pf_data_vld),
    .pf_empty(pf_empty), .pf_full(pf_full), .pf_ovf(pf_ovf)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_sta(input logic [11:0] id);
    @(negedge clk); sta_load = 1'b1; sta_id_in = id;
    @(negedge clk); sta_load = 1'b0;
  endtask

  task automatic new_payload();
    pl.delete();
    repeat (OFS) pl.push_back(8'hEE);
  endtask

  task automatic add_ent(input logic [31:0] w);
    pl.push_back(w[31:24]); pl.push_back(w[23:16]);
    pl.push_back(w[15:8]);  pl.push_back(w[7:0]);
  endtask

  // hook: stream index after which pf_rd is pulsed for one cycle
  task automatic send_pkt(input logic fh, input int hook);
    int ncell;
    strm.delete();
    repeat (HDR) strm.push_back(8'h11);
    ncell = (pl.size() + DATA - 1) / DATA;
    for (int c = 0; c < ncell; c++) begin
      for (int b = 0; b < DATA; b++) begin
        int idx = c * DATA + b;
        strm.push_back(idx < pl.size() ? pl[idx] : 8'h00);
      end
      repeat (CRC) strm.push_back(8'hE5);
    end
    @(negedge clk); fh_mark = fh;
    for (int i = 0; i < strm.size(); i++) begin
      @(negedge clk);
      fh_mark  = 1'b0;
      rx_valid = 1'b1;
      rx_byte  = strm[i];
      rx_last  = (i == strm.size() - 1);
      pf_rd    = (i == hook + 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0; pf_rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] exp);
    @(negedge clk); pf_rd = 1'b1;
    @(negedge clk); pf_rd = 1'b0;
    chk({tag, " vld"}, {31'd0, pf_data_vld}, 32'd1);
    chk({tag, " data"}, pf_data, exp);
  endtask

  task automatic pop_none(input string tag);
    @(negedge clk); pf_rd = 1'b1;
    @(negedge clk); pf_rd = 1'b0;
    chk({tag, " no vld"}, {31'd0, pf_data_vld}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 empty", {31'd0, pf_empty}, 32'd1);
    chk("R1 full", {31'd0, pf_full}, 32'd0);
    chk("R1 ovf", {31'd0, pf_ovf}, 32'd0);
    chk("R1 vld", {31'd0, pf_data_vld}, 32'd0);

    // R3: frame header before the station identifier is loaded
    new_payload(); add_ent(32'h8999_0001);
    send_pkt(1'b1, -5);
    chk("R3 nothing before load", {31'd0, pf_empty}, 32'd1);

    load_sta(12'h5A3);
    // R2: unmarked packet after a marked one is ignored
    new_payload(); add_ent(32'h8999_0002); add_ent(32'h25A3_0003);
    send_pkt(1'b0, -5);
    chk("R2 unmarked ignored", {31'd0, pf_empty}, 32'd1);

    // Table walk: R4 R5 R6 R7 R8 R9
    new_payload(); expq.delete();
    for (int i = 0; i < 12; i++) begin
      add_ent(VEC[i][31:0]);
      if (VEC[i][32]) expq.push_back(VEC[i][31:0]);
    end
    add_ent(32'hE000_0000);          // R8 end marker
    add_ent(32'h65A3_0D1C);          // R8 after marker, ignored
    send_pkt(1'b1, -5);
    for (int i = 0; i < expq.size(); i++) pop_chk("R5 R6 R7 table order", expq[i]);
    pop_none("R8 end marker stops scan");

    // R8: entry count limit
    new_payload();
    repeat (MAXE - 1) add_ent(32'h0000_0000);
    add_ent(32'h8001_0001);
    add_ent(32'h8002_0002);
    send_pkt(1'b1, -5);
    pop_chk("R8 last counted entry", 32'h8001_0001);
    pop_none("R8 beyond entry limit");

    // R11: write while full in the same cycle as a read
    new_payload();
    for (int i = 0; i < DEPTH; i++) add_ent(32'h8100_0000 + i);
    send_pkt(1'b1, -5);
    chk("R11 full before", {31'd0, pf_full}, 32'd1);
    new_payload(); add_ent(32'h8200_0099);
    send_pkt(1'b1, HDR + OFS + 3);
    chk("R11 read during push", pf_data, 32'h8100_0000);
    chk("R11 no overflow", {31'd0, pf_ovf}, 32'd0);
    chk("R11 still full", {31'd0, pf_full}, 32'd1);
    for (int i = 1; i < DEPTH; i++) pop_chk("R11 drain", 32'h8100_0000 + i);
    pop_chk("R11 new entry kept", 32'h8200_0099);
    pop_none("R9 empty read");

    // R10: overflow drops and sticks
    new_payload();
    for (int i = 0; i < DEPTH + 2; i++) add_ent(32'h8300_0000 + i);
    send_pkt(1'b1, -5);
    chk("R10 ovf set", {31'd0, pf_ovf}, 32'd1);
    for (int i = 0; i < DEPTH; i++) pop_chk("R10 first kept", 32'h8300_0000 + i);
    pop_none("R10 extra dropped");
    chk("R10 ovf sticky", {31'd0, pf_ovf}, 32'd1);
    do_reset();
    chk("R10 R1 ovf cleared by reset", {31'd0, pf_ovf}, 32'd0);
    chk("R1 empty after reset", {31'd0, pf_empty}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule